// File: doc/BRIEF.md
# Configuration Memory Boot Loader

After reset this block reads a small serial configuration memory one byte at a time and decides how the device will present itself to the host. It asks for each byte through a request/valid read port. The serial bus master that serves the port sits outside the block. The block first checks a marker byte. It then loads two interface setup registers and checks a second marker. Next it assembles a two-byte descriptor length and takes one of two paths: it either captures three 16-bit identifiers for a built-in default descriptor, or it streams every descriptor byte out through a RAM write port.

When no memory is fitted, or a marker is wrong, or the length is unusable, the block stops reading. Its mode code then tells the rest of the chip to wait for the external master to supply the descriptor. The address strap of the memory selects how many address bytes the serial master sends. The block passes this choice on as `rd_wide` and limits `rd_addr` to match. A single `done` pulse, together with a held 2-bit mode, marks the end of the boot sequence.

Top module: `cfg_boot_loader`

## Requirements
- R1: While `rst` is high and in the first cycle after it: `done`=0, `mode`=0, `rd_req`=0, `desc_we`=0, and `if_cfg` and `pol_cfg` are 0.
- R2: If `mem_present` is 0 when the block leaves reset, it issues no read and pulses `done` with `mode`=0 (no memory).
- R3: The marker value is 0xC4. If memory byte 0 differs from it, exactly one read is made, `done` pulses with `mode`=0, and `if_cfg`/`pol_cfg` stay 0.
- R4: Byte 1 is loaded into `if_cfg` and byte 2 into `pol_cfg`. If byte 3 differs from 0xC4, exactly four reads are made and `mode`=1 (configuration only).
- R5: The length is byte 4 (low) and byte 5 (high). A length of 0 or above 500 gives `mode`=1 after exactly six reads, with no descriptor write.
- R6: A length of exactly 6 causes bytes 6..11 to be read. `vid`={b7,b6}, `pid`={b9,b8} and `did`={b11,b10}. `mode`=2 and no descriptor write occurs.
- R7: Any other length L in 1..500 writes memory byte 6+k to descriptor address k, for k=0..L-1, in increasing order. It ends with `mode`=3 and `desc_len`=L.
- R8: With `addr_strap`=3'b001, `rd_wide`=1 and `rd_addr` carries the full 16-bit byte index. With any other strap, `rd_wide`=0, `rd_addr[15:8]`=0 and `rd_addr[7:0]` is the index modulo 256.
- R9: Reads are strictly sequential from index 0. `rd_req` stays high with a stable `rd_addr` until `rd_valid` is seen, and a new request starts only after the previous one is answered.
- R10: `done` is high for exactly one cycle per boot, and no read request follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; boot starts when it is released |
| mem_present | input | 1 | Serial configuration memory detected |
| addr_strap | input | 3 | Device address strap of the memory |
| rd_req | output | 1 | Byte read request, held until answered |
| rd_addr | output | 16 | Byte index being requested |
| rd_wide | output | 1 | 1 = two address bytes, 0 = one address byte |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_data | input | 8 | Read data byte |
| if_cfg | output | 8 | Interface setup register |
| pol_cfg | output | 8 | Flag polarity register |
| vid | output | 16 | Vendor identifier (default path) |
| pid | output | 16 | Product identifier (default path) |
| did | output | 16 | Device release identifier (default path) |
| desc_we | output | 1 | Descriptor RAM write enable |
| desc_waddr | output | 9 | Descriptor RAM write address |
| desc_wdata | output | 8 | Descriptor RAM write data |
| desc_len | output | 9 | Descriptor length (valid in mode 3) |
| done | output | 1 | One-cycle boot completion pulse |
| mode | output | 2 | 0 none, 1 config only, 2 default IDs, 3 full descriptor |

## Verification
The bench goes after the length boundaries: 0, 1, 6, 7, 500, 501, and 262. The value 262 has a non-zero high byte, so a design that swapped the two length bytes would take the wrong path or write the wrong number of bytes. A failed first marker must leave the setup registers untouched and stop after one read, and a failed second marker must stop after four. A design that ignored either marker would keep reading and report a higher mode. One-byte strapping is tested with a plain 0 strap and with a non-0/1 strap, and with full index wrap on a long descriptor. A design that leaked upper address bits, or that issued a second request before the first was answered, would miss the bench's sequential-index check on every request. Reply latencies of zero to several cycles expose any design that samples the data before `rd_valid`.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_CFG   = 2'd1,
    MODE_DEFID = 2'd2,
    MODE_FULL  = 2'd3
  } boot_mode_e;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_WAIT = 2'd1,
    ST_END  = 2'd2
  } boot_state_e;

  typedef enum logic {
    PATH_DEF  = 1'b0,
    PATH_FULL = 1'b1
  } body_path_e;
endpackage

// File: rtl/boot_len_check.sv
module boot_len_check #(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 500,
  parameter int DEF_LEN = 6
) (
  input  logic [LEN_W-1:0] len,
  output logic             len_ok,
  output logic             len_default
);
  always_comb begin
    len_default = (len == LEN_W'(DEF_LEN));
    len_ok      = (len != '0) && (len <= LEN_W'(MAX_LEN));
  end
endmodule

// File: rtl/boot_rd_port.sv
module boot_rd_port #(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss,
  input  logic [ADDR_W-1:0] iss_idx,
  input  logic              wide,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              byte_vld,
  output logic [7:0]        byte_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (rd_req && rd_valid) begin
        rd_req   <= 1'b0;
        byte_vld <= 1'b1;
        byte_q   <= rd_data;
      end else if (iss) begin
        rd_req  <= 1'b1;
        rd_addr <= wide ? iss_idx : ADDR_W'(iss_idx[NARROW_W-1:0]);
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    iss |-> !rd_req); // R9
  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wide) |-> (rd_addr[ADDR_W-1:NARROW_W] == '0)); // R8
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         LEN_W   = 16,
  parameter int         MAX_LEN = 500,
  parameter int         DEF_LEN = 6,
  parameter logic [7:0] MARKER  = 8'hC4,
  localparam int        DW      = $clog2(MAX_LEN + 1),
  localparam int        HDR     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_present,
  input  logic              byte_vld,
  input  logic [7:0]        byte_q,
  output logic              iss,
  output logic [ADDR_W-1:0] iss_idx,
  output logic [7:0]        if_cfg,
  output logic [7:0]        pol_cfg,
  output logic [15:0]       vid,
  output logic [15:0]       pid,
  output logic [15:0]       did,
  output logic              desc_we,
  output logic [DW-1:0]     desc_waddr,
  output logic [7:0]        desc_wdata,
  output logic [DW-1:0]     desc_len,
  output logic              done,
  output boot_mode_e        mode
);
  boot_state_e       state;
  body_path_e        path;
  logic [ADDR_W-1:0] idx;
  logic [LEN_W-1:0]  len;
  logic [LEN_W-1:0]  len_cand;
  logic              len_ok, len_default;
  logic              fin;
  boot_mode_e        fin_mode;

  assign len_cand = {byte_q, len[7:0]};

  boot_len_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .DEF_LEN(DEF_LEN)) u_len (
    .len         (len_cand),
    .len_ok      (len_ok),
    .len_default (len_default)
  );

  // Decide whether the byte now arriving ends the boot sequence.
  always_comb begin
    fin      = 1'b0;
    fin_mode = MODE_NONE;
    if (idx == ADDR_W'(0) && byte_q != MARKER) begin
      fin = 1'b1;
      fin_mode = MODE_NONE;
    end else if (idx == ADDR_W'(3) && byte_q != MARKER) begin
      fin = 1'b1;
      fin_mode = MODE_CFG;
    end else if (idx == ADDR_W'(5) && !len_ok) begin
      fin = 1'b1;
      fin_mode = MODE_CFG;
    end else if (idx >= ADDR_W'(HDR) && path == PATH_DEF && idx == ADDR_W'(HDR + 5)) begin
      fin = 1'b1;
      fin_mode = MODE_DEFID;
    end else if (idx >= ADDR_W'(HDR) && path == PATH_FULL &&
                 idx == ADDR_W'(len) + ADDR_W'(HDR - 1)) begin
      fin = 1'b1;
      fin_mode = MODE_FULL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_BOOT;
      path       <= PATH_DEF;
      idx        <= '0;
      len        <= '0;
      iss        <= 1'b0;
      iss_idx    <= '0;
      if_cfg     <= '0;
      pol_cfg    <= '0;
      vid        <= '0;
      pid        <= '0;
      did        <= '0;
      desc_we    <= 1'b0;
      desc_waddr <= '0;
      desc_wdata <= '0;
      desc_len   <= '0;
      done       <= 1'b0;
      mode       <= MODE_NONE;
    end else begin
      iss     <= 1'b0;
      desc_we <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_BOOT: begin
          if (mem_present) begin
            iss     <= 1'b1;
            iss_idx <= '0;
            idx     <= '0;
            state   <= ST_WAIT;
          end else begin
            done  <= 1'b1;
            mode  <= MODE_NONE;
            state <= ST_END;
          end
        end
        ST_WAIT: begin
          if (byte_vld) begin
            case (idx)
              ADDR_W'(1): if_cfg <= byte_q;
              ADDR_W'(2): pol_cfg <= byte_q;
              ADDR_W'(4): len[7:0] <= byte_q;
              ADDR_W'(5): begin
                len      <= len_cand;
                desc_len <= DW'(len_cand);
                path     <= len_default ? PATH_DEF : PATH_FULL;
              end
              default: begin
                if (idx >= ADDR_W'(HDR)) begin
                  if (path == PATH_DEF) begin
                    case (idx)
                      ADDR_W'(HDR + 0): vid[7:0]  <= byte_q;
                      ADDR_W'(HDR + 1): vid[15:8] <= byte_q;
                      ADDR_W'(HDR + 2): pid[7:0]  <= byte_q;
                      ADDR_W'(HDR + 3): pid[15:8] <= byte_q;
                      ADDR_W'(HDR + 4): did[7:0]  <= byte_q;
                      default:          did[15:8] <= byte_q;
                    endcase
                  end else begin
                    desc_we    <= 1'b1;
                    desc_waddr <= DW'(idx - ADDR_W'(HDR));
                    desc_wdata <= byte_q;
                  end
                end
              end
            endcase
            if (fin) begin
              done  <= 1'b1;
              mode  <= fin_mode;
              state <= ST_END;
            end else begin
              iss     <= 1'b1;
              iss_idx <= idx + ADDR_W'(1);
              idx     <= idx + ADDR_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_END) |-> !iss); // R10
  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    desc_we |-> (int'(desc_waddr) < MAX_LEN)); // R7
  AST_DEFID_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    desc_we |-> (path == PATH_FULL)); // R6
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import boot_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         MAX_LEN    = 500,
  parameter int         DEF_LEN    = 6,
  parameter logic [7:0] MARKER     = 8'hC4,
  parameter logic [2:0] WIDE_STRAP = 3'b001,
  localparam int        DW         = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_present,
  input  logic [2:0]        addr_strap,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_wide,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic [7:0]        if_cfg,
  output logic [7:0]        pol_cfg,
  output logic [15:0]       vid,
  output logic [15:0]       pid,
  output logic [15:0]       did,
  output logic              desc_we,
  output logic [DW-1:0]     desc_waddr,
  output logic [7:0]        desc_wdata,
  output logic [DW-1:0]     desc_len,
  output logic              done,
  output logic [1:0]        mode
);
  logic              iss;
  logic [ADDR_W-1:0] iss_idx;
  logic              byte_vld;
  logic [7:0]        byte_q;
  logic              wide_q;
  boot_mode_e        mode_e;

  always_ff @(posedge clk) begin
    wide_q <= (addr_strap == WIDE_STRAP);
  end

  assign rd_wide = wide_q;
  assign mode    = mode_e;

  boot_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(16), .MAX_LEN(MAX_LEN),
    .DEF_LEN(DEF_LEN), .MARKER(MARKER)
  ) u_ctrl (
    .clk(clk), .rst(rst), .mem_present(mem_present),
    .byte_vld(byte_vld), .byte_q(byte_q),
    .iss(iss), .iss_idx(iss_idx),
    .if_cfg(if_cfg), .pol_cfg(pol_cfg),
    .vid(vid), .pid(pid), .did(did),
    .desc_we(desc_we), .desc_waddr(desc_waddr), .desc_wdata(desc_wdata),
    .desc_len(desc_len), .done(done), .mode(mode_e)
  );

  boot_rd_port #(.ADDR_W(ADDR_W), .NARROW_W(8)) u_rd (
    .clk(clk), .rst(rst), .iss(iss), .iss_idx(iss_idx), .wide(wide_q),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .byte_vld(byte_vld), .byte_q(byte_q)
  );
endmodule

// File: tb/cfg_boot_loader_bench.sv
module cfg_boot_loader_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_present = 1'b0;
  logic [2:0]  addr_strap = 3'b000;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_wide;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic [7:0]  if_cfg, pol_cfg;
  logic [15:0] vid, pid, did;
  logic        desc_we;
  logic [8:0]  desc_waddr, desc_len;
  logic [7:0]  desc_wdata;
  logic        done;
  logic [1:0]  mode;

  always #2 clk = ~clk;

  cfg_boot_loader u_cfg_boot_loader (
    .clk(clk), .rst(rst), .mem_present(mem_present), .addr_strap(addr_strap),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_wide(rd_wide),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .if_cfg(if_cfg), .pol_cfg(pol_cfg), .vid(vid), .pid(pid), .did(did),
    .desc_we(desc_we), .desc_waddr(desc_waddr), .desc_wdata(desc_wdata),
    .desc_len(desc_len), .done(done), .mode(mode)
  );

  logic [7:0] mem [0:1023];
  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  int nreads = 0;
  int done_seen = 0;
  bit prev_done = 1'b0;
  bit wide_exp = 1'b0;
  bit bench_over = 1'b0;
  int exp_mode, exp_reads, exp_if, exp_pol, exp_vid, exp_pid, exp_did, exp_len;
  int exp_wa[$];
  int exp_wd[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rb(input int i);
    return wide_exp ? int'(mem[i]) : int'(mem[i % 256]);
  endfunction

  // Read responder with per-request address check (R8, R9, R10)
  always @(negedge clk) begin
    if (rst) begin
      rd_valid = 1'b0;
      cnt = 0;
    end else if (rd_valid) begin
      rd_valid = 1'b0;
    end else if (rd_req) begin
      if (cnt >= lat) begin
        check(done_seen == 0, "R10", "request after done", done_seen, 0);
        check(rd_addr == (wide_exp ? nreads : nreads % 256), "R9",
              "sequential read index", rd_addr, wide_exp ? nreads : nreads % 256);
        rd_data = mem[wide_exp ? int'(rd_addr) : int'(rd_addr[7:0])];
        rd_valid = 1'b1;
        nreads++;
        cnt = 0;
      end else begin
        cnt++;
      end
    end
  end

  // Per-clock reference comparison of writes and the done pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (desc_we) begin
        if (exp_wa.size() == 0) begin
          check(1'b0, exp_mode == 2 ? "R6" : "R7", "unexpected descriptor write",
                desc_waddr, 0);
        end else begin
          check(desc_waddr == exp_wa[0] && desc_wdata == exp_wd[0], "R7",
                "descriptor write addr/data", {desc_waddr, desc_wdata},
                {exp_wa[0][8:0], exp_wd[0][7:0]});
          void'(exp_wa.pop_front());
          void'(exp_wd.pop_front());
        end
      end
      if (done && prev_done) check(1'b0, "R10", "done longer than one cycle", 1, 0);
      if (done) done_seen++;
      prev_done = done;
    end else begin
      prev_done = 1'b0;
    end
  end

  task automatic fill(input int b0, input int b1, input int b2, input int b3,
                      input int len, input int seed);
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 13 + seed) & 255);
    mem[0] = 8'(b0); mem[1] = 8'(b1); mem[2] = 8'(b2); mem[3] = 8'(b3);
    mem[4] = 8'(len & 255); mem[5] = 8'((len >> 8) & 255);
  endtask

  task automatic build_expect(input bit present);
    int len;
    exp_wa.delete(); exp_wd.delete();
    exp_if = 0; exp_pol = 0; exp_vid = 0; exp_pid = 0; exp_did = 0; exp_len = 0;
    if (!present) begin
      exp_mode = 0; exp_reads = 0;
    end else if (rb(0) != 'hC4) begin
      exp_mode = 0; exp_reads = 1;
    end else begin
      exp_if = rb(1); exp_pol = rb(2);
      if (rb(3) != 'hC4) begin
        exp_mode = 1; exp_reads = 4;
      end else begin
        len = rb(4) + 256 * rb(5);
        if (len == 0 || len > 500) begin
          exp_mode = 1; exp_reads = 6;
        end else if (len == 6) begin
          exp_mode = 2; exp_reads = 12;
          exp_vid = rb(6) + 256 * rb(7);
          exp_pid = rb(8) + 256 * rb(9);
          exp_did = rb(10) + 256 * rb(11);
        end else begin
          exp_mode = 3; exp_reads = 6 + len; exp_len = len;
          for (int k = 0; k < len; k++) begin
            exp_wa.push_back(k);
            exp_wd.push_back(rb(6 + k));
          end
        end
      end
    end
  endtask

  task automatic run_case(input string name, input bit present,
                          input logic [2:0] strap, input int latency);
    bit got;
    @(negedge clk);
    rst = 1'b1;
    mem_present = present;
    addr_strap = strap;
    lat = latency;
    wide_exp = (strap == 3'b001);
    build_expect(present);
    repeat (3) @(negedge clk);
    nreads = 0;
    done_seen = 0;
    rst = 1'b0;
    got = 1'b0;
    for (int c = 0; c < 6000 && !got; c++) begin
      @(posedge clk);
      if (done_seen > 0) got = 1'b1;
    end
    check(got, "R10", {name, " done seen"}, got, 1);
    repeat (4) @(posedge clk);
    #1;
    check(done_seen == 1, "R10", {name, " done count"}, done_seen, 1);
    check(mode == 2'(exp_mode), exp_mode == 0 ? "R2" : "R5",
          {name, " mode"}, mode, exp_mode);
    check(nreads == exp_reads, "R9", {name, " read count"}, nreads, exp_reads);
    check(if_cfg == 8'(exp_if) && pol_cfg == 8'(exp_pol), "R4",
          {name, " if/pol cfg"}, {if_cfg, pol_cfg}, {exp_if[7:0], exp_pol[7:0]});
    check(rd_wide == wide_exp, "R8", {name, " rd_wide"}, rd_wide, wide_exp);
    check(exp_wa.size() == 0, "R7", {name, " missing writes"}, exp_wa.size(), 0);
    if (exp_mode == 2)
      check(vid == 16'(exp_vid) && pid == 16'(exp_pid) && did == 16'(exp_did), "R6",
            {name, " ids"}, {vid, pid}, {exp_vid[15:0], exp_pid[15:0]});
    if (exp_mode == 3)
      check(desc_len == 9'(exp_len), "R7", {name, " desc_len"}, desc_len, exp_len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 0 && mode == 0 && rd_req == 0 && desc_we == 0, "R1",
          "reset outputs", {done, mode, rd_req, desc_we}, 0);
    check(if_cfg == 0 && pol_cfg == 0, "R1", "reset cfg regs", {if_cfg, pol_cfg}, 0);

    fill('hC4, 'h11, 'h22, 'hC4, 6, 1);
    run_case("R2 absent", 1'b0, 3'b000, 1);

    fill('h55, 'h11, 'h22, 'hC4, 6, 2);
    run_case("R3 bad marker0", 1'b1, 3'b000, 2);

    fill('hC4, 'hA5, 'h3C, 'h00, 6, 3);
    run_case("R4 bad marker3", 1'b1, 3'b000, 0);

    fill('hC4, 'h01, 'h02, 'hC4, 0, 4);
    run_case("R5 len0", 1'b1, 3'b001, 1);

    fill('hC4, 'h03, 'h04, 'hC4, 501, 5);
    run_case("R5 len501", 1'b1, 3'b001, 2);

    fill('hC4, 'h5A, 'h0F, 'hC4, 6, 6);
    mem[6] = 8'h47; mem[7] = 8'h05; mem[8] = 8'h02;
    mem[9] = 8'h10; mem[10] = 8'h01; mem[11] = 8'h00;
    run_case("R6 default narrow", 1'b1, 3'b000, 1);
    check(vid == 16'h0547 && pid == 16'h1002 && did == 16'h0001, "R6",
          "example ids", vid, 16'h0547);

    fill('hC4, 'h77, 'h88, 'hC4, 6, 7);
    run_case("R6 default wide", 1'b1, 3'b001, 3);

    fill('hC4, 'h10, 'h20, 'hC4, 5, 8);
    run_case("R7 len5", 1'b1, 3'b000, 0);

    fill('hC4, 'h10, 'h20, 'hC4, 7, 9);
    run_case("R7 len7", 1'b1, 3'b000, 3);

    fill('hC4, 'h10, 'h20, 'hC4, 1, 10);
    run_case("R7 len1", 1'b1, 3'b001, 1);

    fill('hC4, 'h31, 'h32, 'hC4, 500, 11);
    run_case("R7 len500 wide", 1'b1, 3'b001, 0);

    fill('hC4, 'h41, 'h42, 'hC4, 262, 12);
    run_case("R8 len262 narrow wrap", 1'b1, 3'b000, 1);

    fill('hC4, 'h51, 'h52, 'hC4, 262, 13);
    run_case("R8 len262 strap010", 1'b1, 3'b010, 2);

    bench_over = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!bench_over) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule